// File: doc/BRIEF.md
# Multi-Mode Output Response Compactor

This block squeezes the stream of responses from a circuit under test into one short value per output line, so that a self-test session ends with a few words to compare instead of a full response log. Each session runs in one of three compression styles, picked when the session opens: counting the samples on which a line is high, counting how often a line changes between consecutive samples, or dividing the line's bit stream by the degree-4 polynomial x^4 + x + 1 and keeping the 4-bit remainder.

A session opens with a start strobe and closes with an end strobe. In between, each cycle with the valid strobe high feeds one response sample, one bit per output, into the per-line accumulators. When the session closes, every accumulator is compared with its fault-free value on the golden input. One cycle later a done pulse appears together with a pass flag and a mask of the failing lines. Choosing the patterns and computing the golden values happen outside the block. Any compression can alias: a faulty stream that compresses to the golden value passes.

Top module: `resp_compactor`

## Requirements
- R1: After reset, done_o, pass_o and fail_mask_o are all low.
- R2: mode_i is captured on the start cycle and holds for the whole session: 2'b00 counts ones, 2'b01 counts transitions, 2'b10 builds a signature, and 2'b11 counts ones. Changing mode_i inside a session has no effect.
- R3: In ones mode, each line's counter increases by one for every accepted sample on which that line is 1.
- R4: In transition mode, a line's counter increases by one whenever an accepted sample differs from the previous accepted sample on that line, in either direction. The first accepted sample of a session is never counted.
- R5: In signature mode, each accepted bit b updates the 4-bit remainder r to {r[2:0], b} XOR (r[3] ? 4'b0011 : 4'b0000), starting from zero. The remainder sits in the low 4 bits of the line's value, and the upper bits are zero.
- R6: Counters stop at 2^CNT_W-1 instead of wrapping.
- R7: A start clears all accumulators. Samples are accepted only while a session is open, with valid_i high, and never in a cycle that also carries start_i or end_i.
- R8: end_i in an open session gives a done_o pulse exactly one cycle long, on the cycle after end_i. end_i with no open session gives no done_o.
- R9: With done_o, fail_mask_o bit i is set exactly when line i's value differs from golden_i[i*CNT_W +: CNT_W], and pass_o is high exactly when no bit is set. Both hold their values until the next done_o.
- R10: A signature run whose bit stream differs from the fault-free stream by a multiple of x^4 + x + 1 passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Compression style, captured at session start |
| start_i | input | 1 | Opens a session and clears the accumulators |
| valid_i | input | 1 | A response sample is present on resp_i |
| resp_i | input | N_OUT | One response bit per output line |
| end_i | input | 1 | Closes the session and triggers the comparison |
| golden_i | input | N_OUT*CNT_W | Fault-free values, line i in bits i*CNT_W +: CNT_W |
| done_o | output | 1 | One-cycle pulse marking a new result |
| pass_o | output | 1 | All lines matched at the last comparison |
| fail_mask_o | output | N_OUT | Per-line mismatch at the last comparison |

## Verification
The bench goes after several edges of a session:
- Samples sent on the start and end cycles. A design that accepted them would be off by one in ones mode.
- A first sample that differs from the stale previous bit of a new session. Counting it would inflate transition counts.
- Runs longer than the counter range. A wrapping counter would compare small and fail.
- A session in which mode_i changes mid-run. A design that did not latch the mode would mix compression styles.
- An end strobe with no open session. It must produce no pulse.
- A deliberately aliasing signature stream. It proves the remainder is a true division by x^4 + x + 1, where any other feedback would report a failure.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    MODE_ONES  = 2'b00,
    MODE_TRANS = 2'b01,
    MODE_SIG   = 2'b10,
    MODE_ONES2 = 2'b11
  } rc_mode_e;

  localparam int SIG_W = 4;
  // low-order taps of x^4 + x + 1
  localparam logic [SIG_W-1:0] SIG_TAPS = 4'b0011;
endpackage

// File: rtl/rc_lane.sv
module rc_lane
  import rc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic             first,
  input  rc_mode_e         mode,
  input  logic             bit_i,
  output logic [CNT_W-1:0] acc_o
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  localparam int PAD_W = CNT_W - SIG_W;

  logic             prev_q;
  logic [SIG_W-1:0] rem;
  logic [SIG_W-1:0] rem_nx;
  logic             bump;

  always_comb begin
    rem    = acc_o[SIG_W-1:0];
    rem_nx = {rem[SIG_W-2:0], bit_i} ^ (rem[SIG_W-1] ? SIG_TAPS : '0);
    case (mode)
      MODE_TRANS: bump = !first && (bit_i != prev_q);
      MODE_SIG:   bump = 1'b0;
      default:    bump = bit_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_o  <= '0;
      prev_q <= 1'b0;
    end else if (step) begin
      prev_q <= bit_i;
      if (mode == MODE_SIG)
        acc_o <= {{PAD_W{1'b0}}, rem_nx};
      else if (bump && acc_o != MAXV)
        acc_o <= acc_o + 1'b1;
    end
  end
endmodule

// File: rtl/rc_judge.sv
module rc_judge #(
  parameter int N_OUT = 4,
  parameter int CNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fire,
  input  logic [N_OUT*CNT_W-1:0] acc_flat,
  input  logic [N_OUT*CNT_W-1:0] gold_flat,
  output logic                   done_o,
  output logic                   pass_o,
  output logic [N_OUT-1:0]       fail_mask_o
);
  logic [N_OUT-1:0] miss;

  for (genvar g = 0; g < N_OUT; g++) begin : g_cmp
    assign miss[g] = acc_flat[g*CNT_W +: CNT_W] != gold_flat[g*CNT_W +: CNT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o      <= 1'b0;
      pass_o      <= 1'b0;
      fail_mask_o <= '0;
    end else begin
      done_o <= fire;
      if (fire) begin
        fail_mask_o <= miss;
        pass_o      <= ~|miss;
      end
    end
  end
endmodule

// File: rtl/resp_compactor.sv
module resp_compactor
  import rc_pkg::*;
#(
  parameter int N_OUT = 4,
  parameter int CNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             mode_i,
  input  logic                   start_i,
  input  logic                   valid_i,
  input  logic [N_OUT-1:0]       resp_i,
  input  logic                   end_i,
  input  logic [N_OUT*CNT_W-1:0] golden_i,
  output logic                   done_o,
  output logic                   pass_o,
  output logic [N_OUT-1:0]       fail_mask_o
);
  localparam int ACC_W = N_OUT * CNT_W;

  logic             active_q;
  logic             seen_q;
  rc_mode_e         mode_q;
  logic             step;
  logic             fire;
  logic [ACC_W-1:0] acc_flat;

  assign step = valid_i && active_q && !start_i && !end_i;
  assign fire = end_i && active_q && !start_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      seen_q   <= 1'b0;
      mode_q   <= MODE_ONES;
    end else if (start_i) begin
      active_q <= 1'b1;
      seen_q   <= 1'b0;
      mode_q   <= rc_mode_e'(mode_i);
    end else begin
      if (end_i) active_q <= 1'b0;
      if (step)  seen_q   <= 1'b1;
    end
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_lane
    rc_lane #(.CNT_W(CNT_W)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .clr   (start_i),
      .step  (step),
      .first (!seen_q),
      .mode  (mode_q),
      .bit_i (resp_i[g]),
      .acc_o (acc_flat[g*CNT_W +: CNT_W])
    );
  end

  rc_judge #(.N_OUT(N_OUT), .CNT_W(CNT_W)) u_judge (
    .clk         (clk),
    .rst         (rst),
    .fire        (fire),
    .acc_flat    (acc_flat),
    .gold_flat   (golden_i),
    .done_o      (done_o),
    .pass_o      (pass_o),
    .fail_mask_o (fail_mask_o)
  );
endmodule

// File: rtl/rc_chk.sv
module rc_chk #(
  parameter int N_OUT = 4,
  parameter int CNT_W = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   start_i,
  input logic                   end_i,
  input logic                   active_q,
  input logic [1:0]             mode_q,
  input logic [N_OUT*CNT_W-1:0] acc_flat,
  input logic                   done_o,
  input logic                   pass_o,
  input logic [N_OUT-1:0]       fail_mask_o
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R8
  stray_end_chk: assert property (@(posedge clk) disable iff (rst)
    (end_i && !active_q) |=> !done_o);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(end_i && active_q) |=> ($stable(pass_o) && $stable(fail_mask_o)));

  // R6
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_flat[CNT_W-1:0] == MAXV && mode_q != 2'b10 && !start_i)
      |=> acc_flat[CNT_W-1:0] == MAXV);

  // R5
  sig_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'b10) |-> (acc_flat[CNT_W-1:0] >> 4) == '0);

  // R7
  closed_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!active_q && !start_i) |=> $stable(acc_flat));

  // R7
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> acc_flat == '0);
endmodule

bind resp_compactor rc_chk #(.N_OUT(N_OUT), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .end_i       (end_i),
  .active_q    (active_q),
  .mode_q      (mode_q),
  .acc_flat    (acc_flat),
  .done_o      (done_o),
  .pass_o      (pass_o),
  .fail_mask_o (fail_mask_o)
);

// File: tb/sim_resp_compactor.sv
module sim_resp_compactor;
  localparam int N = 4;
  localparam int W = 8;
  localparam int MAXP = 512;

  typedef struct {
    logic       pass;
    logic [N-1:0] mask;
    string      tag;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [1:0]     mode_i = 2'b00;
  logic           start_i = 1'b0;
  logic           valid_i = 1'b0;
  logic [N-1:0]   resp_i = '0;
  logic           end_i = 1'b0;
  logic [N*W-1:0] golden_i = '0;
  logic           done_o;
  logic           pass_o;
  logic [N-1:0]   fail_mask_o;

  int   n_chk = 0;
  int   n_bad = 0;
  int   n_done = 0;
  exp_t sb[$];
  logic [N-1:0] pat [MAXP];
  logic [N-1:0] gref [MAXP];

  always #10 clk = ~clk;

  resp_compactor #(.N_OUT(N), .CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .mode_i(mode_i), .start_i(start_i),
    .valid_i(valid_i), .resp_i(resp_i), .end_i(end_i), .golden_i(golden_i),
    .done_o(done_o), .pass_o(pass_o), .fail_mask_o(fail_mask_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a result appears
  always @(negedge clk) begin
    if (!rst && done_o) begin
      n_done++;
      if (sb.size() == 0) begin
        check(1'b0, "R8 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(pass_o == e.pass, {e.tag, " pass"}, pass_o, e.pass);
        check(fail_mask_o == e.mask, {e.tag, " mask"}, fail_mask_o, e.mask);
      end
    end
  end

  // reference value of one lane, from the requirements
  function automatic logic [W-1:0] model(input logic [1:0] md, input int n, input int l);
    logic [W-1:0] c;
    logic [3:0]   r;
    c = '0;
    r = '0;
    for (int i = 0; i < n; i++) begin
      if (md == 2'b10) begin
        r = {r[2:0], gref[i][l]} ^ (r[3] ? 4'b0011 : 4'b0000);
      end else if (md == 2'b01) begin
        if (i > 0 && gref[i][l] != gref[i-1][l] && c != '1) c = c + 1'b1;
      end else begin
        if (gref[i][l] && c != '1) c = c + 1'b1;
      end
    end
    if (md == 2'b10) c = {{(W-4){1'b0}}, r};
    return c;
  endfunction

  // driver: runs one session over pat[0..n-1]; golden from gref
  task automatic run(input logic [1:0] md, input int n, input int bad_lane, input string tag);
    exp_t e;
    logic [N*W-1:0] g;
    e.mask = '0;
    for (int l = 0; l < N; l++) begin
      logic [W-1:0] v;
      v = model(md, n, l);
      if (l == bad_lane) begin
        v = v ^ 8'h01;
        e.mask[l] = 1'b1;
      end
      g[l*W +: W] = v;
    end
    e.pass = (e.mask == '0);
    e.tag  = tag;
    @(negedge clk);
    start_i = 1'b1; mode_i = md; valid_i = 1'b1; resp_i = '1;  // R7 start-cycle sample ignored
    @(negedge clk);
    start_i = 1'b0; mode_i = ~md;                              // R2 late mode change ignored
    for (int i = 0; i < n; i++) begin
      if (i % 3 == 1) begin
        valid_i = 1'b0; resp_i = ~pat[i];
        @(negedge clk);
      end
      valid_i = 1'b1; resp_i = pat[i];
      @(negedge clk);
    end
    golden_i = g;
    sb.push_back(e);
    end_i = 1'b1; valid_i = 1'b1; resp_i = '1;                 // R7 end-cycle sample ignored
    @(negedge clk);
    end_i = 1'b0; valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic fill_rand(input int n);
    for (int i = 0; i < n; i++) begin
      pat[i]  = N'($urandom);
      gref[i] = pat[i];
    end
  endtask

  initial begin : watchdog
    #(20 * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : stim
    int d0;
    logic p0;
    logic [N-1:0] m0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(done_o == 1'b0, "R1 done", done_o, 0);
    check(pass_o == 1'b0, "R1 pass", pass_o, 0);
    check(fail_mask_o == '0, "R1 mask", fail_mask_o, 0);

    // R3 ones count, also mode 2'b11 (R2)
    fill_rand(40);
    run(2'b00, 40, -1, "R3 ones pass");
    run(2'b00, 40, 2, "R3 ones lane2 mismatch (R9)");
    run(2'b11, 40, -1, "R2 alt ones encoding");

    // R4 transitions; first sample is 1 so a stale previous 0 must not count
    fill_rand(30);
    pat[0] = '1; gref[0] = '1;
    run(2'b01, 30, -1, "R4 transitions pass");
    run(2'b01, 30, 0, "R4 transitions lane0 mismatch (R9)");

    // R5 signature
    fill_rand(50);
    run(2'b10, 50, -1, "R5 signature pass");
    run(2'b10, 50, 3, "R5 signature lane3 mismatch (R9)");

    // R6 saturation, ones and transitions
    for (int i = 0; i < 300; i++) begin
      pat[i] = '1; gref[i] = '1;
    end
    run(2'b00, 300, -1, "R6 ones saturates");
    for (int i = 0; i < 300; i++) begin
      pat[i] = (i % 2) ? '1 : '0; gref[i] = pat[i];
    end
    run(2'b01, 300, -1, "R6 transitions saturate");

    // R10 aliasing: add x^4+x+1 to lane 0 over the last five bits
    fill_rand(60);
    pat[55][0] = ~pat[55][0];
    pat[58][0] = ~pat[58][0];
    pat[59][0] = ~pat[59][0];
    run(2'b10, 60, -1, "R10 aliased stream passes");

    // R8 end without an open session, R9 result held
    d0 = n_done; p0 = pass_o; m0 = fail_mask_o;
    end_i = 1'b1; golden_i = ~golden_i;
    @(negedge clk);
    end_i = 1'b0;
    repeat (4) @(negedge clk);
    check(n_done == d0, "R8 stray end gives no done", n_done, d0);
    check(pass_o == p0, "R9 pass held", pass_o, p0);
    check(fail_mask_o == m0, "R9 mask held", fail_mask_o, m0);
    check(sb.size() == 0, "R8 all results seen", sb.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule